// File: doc/BRIEF.md
# Periodic Counter Clock Calibrator

This block turns an oscillator-rate enable into a corrected one-pulse-per-second tick for a calendar. A two-stage prescaler (a low stage of `LOW_W` bits, the divide-by-256 point at default settings, feeding a high stage of `HIGH_W` bits) counts oscillator ticks. Accuracy is trimmed digitally, not by tuning the crystal load. Over a repeating 64-minute cycle, the first second of each of the first 2×N minutes is either shortened, by skipping one full low-stage wrap, or lengthened, by blanking half a low-stage wrap of oscillator ticks. N is a 5-bit magnitude and a sign bit picks the direction.

An 8-bit control byte is loaded through a write strobe. The same byte drives a test pin. With the test bit set, the pin is a square wave at 1/64 of the oscillator rate (512 Hz at 32768 Hz), taken ahead of the correction point. With the test bit clear, the pin holds a static level.

A per-second state machine settles the shape of each second when that second receives its first tick. **ST_ARM** waits for the first tick of a second. On that tick it goes to **ST_SHORT** (positive correction due), to **ST_BLANK** (negative correction due), or to **ST_PLAIN** (no correction). **ST_BLANK** swallows ticks and moves to **ST_PLAIN** once the blanking count is reached. **ST_PLAIN** and **ST_SHORT** return to **ST_ARM** on the final tick of the second, which is the edge where the second-end pulse is raised.

Top module: `clock_trim_prescaler`

## Requirements
- R1: Control byte fields are bit 7 static pin level, bit 6 test-wave enable, bit 5 sign (1 = speed up, 0 = slow down) and bits 4:0 magnitude N. The byte is taken from `ctrl_wdata` on a clock edge where `ctrl_load` is high. Reset leaves the byte at 8'h80, which is level 1, test off and N = 0.
- R2: An uncorrected second lasts exactly 2^(LOW_W+HIGH_W) oscillator ticks. `sec_tick` is a one-clock pulse in the cycle after the edge that samples the last tick of a second.
- R3: Seconds are numbered 0 to SECS_PER_MIN-1 within a minute, and minutes 0 to 63 within the cycle. Both start at 0 after reset. Second 0 of minute m is corrected when N is nonzero and m < 2×N. No other second is corrected, so with N = 31 minutes 62 and 63 stay untouched.
- R4: A positively corrected second is 2^LOW_W ticks shorter than an uncorrected one.
- R5: A negatively corrected second is 2^(LOW_W-1) ticks longer than an uncorrected one, because those ticks are blanked at its start.
- R6: N = 0 leaves every second uncorrected with either sign.
- R7: With the test bit set, `trim_pin` changes level every 32 oscillator ticks, whatever the sign and magnitude are.
- R8: With the test bit clear, `trim_pin` equals bit 7 of the control byte, one clock after the byte is loaded.
- R9: Only clocks with `osc_tick` high advance the prescaler. Idle clocks between ticks do not change the tick count of any second.
- R10: The 64-minute cycle wraps, so minute 64 after reset is corrected exactly as minute 0 is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock enable at the oscillator rate |
| ctrl_load | input | 1 | Loads the control byte |
| ctrl_wdata | input | 8 | Control byte value |
| sec_tick | output | 1 | Corrected one-per-second pulse |
| trim_pin | output | 1 | Test wave or static level |

## Verification
A wrong state choice made in ST_ARM shows up as a second of the wrong length, one full second later, in the spacing between `sec_tick` pulses. A minute or second index that drifts moves the corrected seconds to the wrong place in the cycle, so the bench measures every second over whole cycles and compares its length with the schedule. A blanking miscount appears as a second that is off by a few ticks. A test divider that is disturbed by correction changes the toggle spacing on `trim_pin` within 32 ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_PLAIN = 2'd1,
        ST_SHORT = 2'd2,
        ST_BLANK = 2'd3
    } sec_state_t;

    typedef struct packed {
        logic       out_lvl;
        logic       ft_en;
        logic       sign_pos;
        logic [4:0] mag;
    } cal_ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h80;
    localparam int         MIN_W      = 6;

endpackage

// File: rtl/cal_ctrl_reg.sv
module cal_ctrl_reg
    import cal_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [7:0]      wdata,
    output cal_ctrl_t       ctrl_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= cal_ctrl_t'(CTRL_RESET);
        else if (load)
            ctrl_q <= cal_ctrl_t'(wdata);
    end

    // R1: the control byte changes only on a load
    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ctrl_q));

endmodule

// File: rtl/cal_schedule.sv
module cal_schedule
    import cal_pkg::*;
#(
    parameter int SECS_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_end,
    input  logic       sign_pos,
    input  logic [4:0] mag,
    output logic       corr_pos,
    output logic       corr_neg
);

    localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

    logic [SEC_W-1:0] sec_idx;
    logic [MIN_W-1:0] min_idx;
    logic             corr_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_idx <= '0;
            min_idx <= '0;
        end else if (sec_end) begin
            if (sec_idx == SEC_LAST) begin
                sec_idx <= '0;
                min_idx <= min_idx + 1'b1;
            end else begin
                sec_idx <= sec_idx + 1'b1;
            end
        end
    end

    always_comb begin
        corr_act = (mag != 5'd0) && (sec_idx == '0) &&
                   ({1'b0, min_idx} < {1'b0, mag, 1'b0});
        corr_pos = corr_act && sign_pos;
        corr_neg = corr_act && !sign_pos;
    end

    // R3: the minute index advances by one at the last second of a minute
    // R10: it wraps from 63 to 0
    assert_minute_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_end && sec_idx == SEC_LAST) |=> min_idx == $past(min_idx) + 1'b1);

    assert_second_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_end |=> ($stable(sec_idx) && $stable(min_idx)));

    assert_single_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_pos && corr_neg));

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_pkg::*;
#(
    parameter int LOW_W  = 8,
    parameter int HIGH_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic corr_pos,
    input  logic corr_neg,
    output logic sec_end,
    output logic sec_tick
);

    localparam logic [LOW_W-1:0]  LOW_MAX   = '1;
    localparam logic [HIGH_W-1:0] HIGH_MAX  = '1;
    localparam logic [HIGH_W-1:0] HIGH_SHRT = HIGH_MAX - 1'b1;
    localparam logic [LOW_W-1:0]  BLANK_END = LOW_W'((2 ** (LOW_W - 1)) - 1);

    sec_state_t        state, state_nx;
    logic [LOW_W-1:0]  low_cnt;
    logic [HIGH_W-1:0] high_cnt;
    logic [LOW_W-1:0]  blank_cnt;
    logic              counting;
    logic              swallow;
    logic              short_sec;
    logic              blank_done;
    logic [HIGH_W-1:0] high_end;

    always_comb begin
        swallow    = osc_tick && ((state == ST_BLANK) || (state == ST_ARM && corr_neg));
        counting   = osc_tick && !swallow;
        short_sec  = (state == ST_SHORT) || (state == ST_ARM && corr_pos);
        high_end   = short_sec ? HIGH_SHRT : HIGH_MAX;
        sec_end    = counting && (low_cnt == LOW_MAX) && (high_cnt == high_end);
        blank_done = swallow && (blank_cnt == BLANK_END);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARM: begin
                if (osc_tick) begin
                    if (sec_end)
                        state_nx = ST_ARM;
                    else if (corr_pos)
                        state_nx = ST_SHORT;
                    else if (corr_neg)
                        state_nx = blank_done ? ST_PLAIN : ST_BLANK;
                    else
                        state_nx = ST_PLAIN;
                end
            end
            ST_PLAIN, ST_SHORT: begin
                if (sec_end)
                    state_nx = ST_ARM;
            end
            ST_BLANK: begin
                if (blank_done)
                    state_nx = ST_PLAIN;
            end
            default: state_nx = ST_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARM;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            high_cnt  <= '0;
            blank_cnt <= '0;
            sec_tick  <= 1'b0;
        end else begin
            sec_tick <= sec_end;
            if (counting) begin
                if (sec_end) begin
                    low_cnt  <= '0;
                    high_cnt <= '0;
                end else begin
                    low_cnt <= low_cnt + 1'b1;
                    if (low_cnt == LOW_MAX)
                        high_cnt <= high_cnt + 1'b1;
                end
            end
            if (swallow)
                blank_cnt <= blank_done ? '0 : blank_cnt + 1'b1;
        end
    end

    // R2: the second pulse lasts one clock
    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R5: blanked ticks leave the divider untouched
    assert_blank_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK) |=> ($stable(low_cnt) && $stable(high_cnt)));

    // R9: no tick, no progress
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> ($stable(low_cnt) && $stable(high_cnt) && $stable(state)));

    // R4: a due positive correction shapes the second as a short one
    assert_short_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && osc_tick && corr_pos) |=> (state == ST_SHORT));

endmodule

// File: rtl/cal_pin_drive.sv
module cal_pin_drive #(
    parameter int HALF_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic ft_en,
    input  logic out_lvl,
    output logic pin_q
);

    logic [HALF_W:0] div_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            pin_q   <= 1'b1;
        end else begin
            if (osc_tick)
                div_cnt <= div_cnt + 1'b1;
            pin_q <= ft_en ? div_cnt[HALF_W] : out_lvl;
        end
    end

    // R8: with the test wave off, the pin follows the level bit
    assert_static_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ft_en |=> (pin_q == $past(out_lvl)));

    // R7: the test divider only moves on oscillator ticks
    assert_divider_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(div_cnt));

endmodule

// File: rtl/clock_trim_prescaler.sv
module clock_trim_prescaler
    import cal_pkg::*;
#(
    parameter int LOW_W        = 8,
    parameter int HIGH_W       = 7,
    parameter int SECS_PER_MIN = 60,
    parameter int TEST_HALF_W  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       ctrl_load,
    input  logic [7:0] ctrl_wdata,
    output logic       sec_tick,
    output logic       trim_pin
);

    cal_ctrl_t ctrl_q;
    logic      sec_end;
    logic      corr_pos;
    logic      corr_neg;

    cal_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctrl_load),
        .wdata  (ctrl_wdata),
        .ctrl_q (ctrl_q)
    );

    cal_schedule #(
        .SECS_PER_MIN (SECS_PER_MIN)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_end  (sec_end),
        .sign_pos (ctrl_q.sign_pos),
        .mag      (ctrl_q.mag),
        .corr_pos (corr_pos),
        .corr_neg (corr_neg)
    );

    cal_prescaler #(
        .LOW_W  (LOW_W),
        .HIGH_W (HIGH_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .corr_pos (corr_pos),
        .corr_neg (corr_neg),
        .sec_end  (sec_end),
        .sec_tick (sec_tick)
    );

    cal_pin_drive #(
        .HALF_W (TEST_HALF_W)
    ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .ft_en    (ctrl_q.ft_en),
        .out_lvl  (ctrl_q.out_lvl),
        .pin_q    (trim_pin)
    );

endmodule

// File: tb/sim_clock_trim_prescaler.sv
`timescale 1ns/1ps
module sim_clock_trim_prescaler;

    localparam int L_W  = 4;
    localparam int H_W  = 2;
    localparam int SPM  = 3;
    localparam int PLAIN_LEN = 64;   // 2^(4+2)
    localparam int SHORT_LEN = 48;   // minus 2^4
    localparam int LONG_LEN  = 72;   // plus 2^3

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ctrl_load = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       sec_tick;
    logic       trim_pin;

    int checks = 0;
    int errors = 0;
    logic tick_run = 1'b0;
    logic gap_mode = 1'b0;

    int tick_cnt = 0, last_len = 0, sec_seq = 0;
    int clk_since = 0, pin_gap = 0, pin_seq = 0;
    logic last_pin = 1'b1;

    always #10 clk = ~clk;

    clock_trim_prescaler #(
        .LOW_W (L_W), .HIGH_W (H_W), .SECS_PER_MIN (SPM), .TEST_HALF_W (5)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .osc_tick (osc_tick),
        .ctrl_load (ctrl_load), .ctrl_wdata (ctrl_wdata),
        .sec_tick (sec_tick), .trim_pin (trim_pin)
    );

    always @(posedge clk) begin
        #1;
        if (!tick_run)     osc_tick = 1'b0;
        else if (gap_mode) osc_tick = ~osc_tick;
        else               osc_tick = 1'b1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            tick_cnt  = 0;
            clk_since = 0;
            last_pin  = trim_pin;
        end else begin
            if (sec_tick) begin
                last_len = tick_cnt;
                sec_seq++;
                tick_cnt = 0;
            end
            if (osc_tick) tick_cnt++;
            clk_since++;
            if (trim_pin != last_pin) begin
                pin_gap = clk_since;
                pin_seq++;
                clk_since = 0;
                last_pin = trim_pin;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tick_run = 1'b0;
        gap_mode = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        @(negedge clk);
        ctrl_load = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_load = 1'b0;
    endtask

    task automatic wait_second(output int len);
        int s0;
        s0 = sec_seq;
        while (sec_seq == s0) begin
            @(negedge clk);
            #1;
        end
        len = last_len;
    endtask

    // R1, R2: reset state of the outputs
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 reset pin level", int'(trim_pin), 1);
        check("R2 reset sec_tick", int'(sec_tick), 0);
    endtask

    // R8, R1: static level follows bit 7
    task automatic t_static();
        do_reset();
        write_ctrl(8'h00);
        @(negedge clk);
        check("R8 level low", int'(trim_pin), 0);
        write_ctrl(8'h80);
        @(negedge clk);
        check("R8 level high", int'(trim_pin), 1);
        write_ctrl(8'h3F);
        @(negedge clk);
        check("R1 sign and magnitude do not touch pin", int'(trim_pin), 0);
    endtask

    // R2..R6, R9, R10: measure every second against the schedule
    task automatic t_run(input string req, input logic sgn, input int mag,
                         input int nsec, input logic gaps);
        int len, m, s, exp;
        do_reset();
        write_ctrl({1'b1, 1'b0, sgn, 5'(mag)});
        gap_mode = gaps;
        @(negedge clk);
        tick_run = 1'b1;
        for (int k = 0; k < nsec; k++) begin
            wait_second(len);
            m = (k / SPM) % 64;
            s = k % SPM;
            if (mag != 0 && s == 0 && m < 2 * mag)
                exp = sgn ? SHORT_LEN : LONG_LEN;
            else
                exp = PLAIN_LEN;
            check($sformatf("%s second %0d", req, k), len, exp);
        end
        tick_run = 1'b0;
    endtask

    // R7: test wave spacing independent of calibration
    task automatic t_ftest(input logic [7:0] d);
        int p0;
        do_reset();
        write_ctrl(d);
        @(negedge clk);
        tick_run = 1'b1;
        p0 = pin_seq;
        while (pin_seq < p0 + 2) begin
            @(negedge clk);
            #1;
        end
        for (int i = 0; i < 12; i++) begin
            p0 = pin_seq;
            while (pin_seq == p0) begin
                @(negedge clk);
                #1;
            end
            check("R7 test wave spacing", pin_gap, 32);
        end
        write_ctrl(8'h05);
        @(negedge clk);
        check("R8 level after test wave", int'(trim_pin), 0);
        tick_run = 1'b0;
    endtask

    initial begin
        t_reset();
        t_static();
        t_run("R6 pos zero", 1'b1, 0, 12, 1'b0);
        t_run("R6 neg zero", 1'b0, 0, 12, 1'b0);
        t_run("R4 R10 pos one", 1'b1, 1, 2 * 64 * SPM, 1'b0);
        t_run("R5 neg six", 1'b0, 6, 64 * SPM, 1'b0);
        t_run("R3 pos max", 1'b1, 31, 64 * SPM, 1'b0);
        t_run("R9 gaps", 1'b0, 2, 24, 1'b1);
        t_ftest(8'h4A);
        t_ftest(8'h7F);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule